// File: doc/BRIEF.md
# Trapping 64-bit Integer Adder Unit

This execution unit serves the integer pipeline of a 64-bit RISC core. Each accepted operation combines two 64-bit register operands, or one register operand and a 16-bit immediate. The operation is an add, a subtract, a signed or unsigned set-less-than, a bitwise logic function or a load-upper-immediate. Add and subtract come in word (32-bit) and doubleword (64-bit) sizes, each with a trapping and a non-trapping variant. A trapping add or subtract that overflows raises an exception flag and withholds the register write. The vectoring of that exception is left to logic outside this unit.

An operation is presented with `in_valid` high for one clock. One clock later, the unit shows the registered result, the destination write enable and the overflow flag, with `out_valid` high. A new operation can be accepted on every clock.

The output side is a two-state machine. `ST_IDLE` means no result is on the outputs. `ST_DONE` means the registered result is valid. Transition `T_ACCEPT` (ST_IDLE to ST_DONE) and transition `T_STREAM` (ST_DONE to ST_DONE) are both taken when `in_valid` is high. Transition `T_DRAIN` (ST_DONE to ST_IDLE) and transition `T_WAIT` (ST_IDLE to ST_IDLE) are both taken when `in_valid` is low. Reset forces ST_IDLE.

Top module: `adder_exec_unit`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for exactly that one cycle. `out_valid` is low after any edge at which `in_valid` was low. While `out_valid` is low, `out_wr_en` and `out_ovf` are low.
- R2: While reset (`rst_n` low) is applied, and immediately after it, `out_valid`, `out_wr_en` and `out_ovf` are 0.
- R3: Word forms use only bits 31:0 of their operands. Their 32-bit result is sign-extended into bits 63:32. The word opcodes are 0 (trapping add), 1 (add), 2 (trapping subtract), 3 (subtract), 8 (trapping add immediate) and 9 (add immediate).
- R4: Add overflow is set when both operands have the same sign and the result's sign differs from them. The sign is taken at bit 31 for word forms and at bit 63 for doubleword forms. On the trapping adds (0, 4 = doubleword, 8, 10 = doubleword immediate), overflow drives `out_ovf` to 1 and `out_wr_en` to 0. `out_result` still carries the wrapped sum.
- R5: A subtract computes a − b. Its overflow is set when the operand signs differ and the result's sign differs from a's sign. On the trapping subtracts (2, 6 = doubleword), overflow drives `out_ovf` to 1 and `out_wr_en` to 0.
- R6: The non-trapping arithmetic opcodes (1, 3, 5 = doubleword add, 7 = doubleword subtract, 9, 11 = doubleword add immediate) always give `out_wr_en` = 1 and `out_ovf` = 0, including on a wrapped result.
- R7: The immediate is sign-extended from 16 bits for the add-immediate opcodes (8 to 11) and the set-less-than-immediate opcodes (14, 15). It is zero-extended for the logic-immediate opcodes: 20 = AND, 21 = OR, 22 = XOR.
- R8: Set-less-than writes 1 when a < b, and 0 otherwise. Opcode 12 is the signed register form and 13 the unsigned register form. Opcode 14 is signed against the immediate. Opcode 15 compares, unsigned, against the sign-extended immediate.
- R9: The register logic opcodes work bitwise over all 64 bits: 16 = AND, 17 = OR, 18 = XOR, 19 = NOR (the inverse of a OR b).
- R10: Load-upper-immediate (opcode 23) ignores `in_a`. It places the immediate in bits 31:16, zeros in bits 15:0, and copies immediate bit 15 into bits 63:32.
- R11: Opcodes 24 to 31 are undefined. They give `out_result` = 0, `out_wr_en` = 0 and `out_ovf` = 0, with `out_valid` still high.
- R12: All opcodes other than the trapping ones and the undefined ones write with `out_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 5 | Operation code |
| in_a | input | 64 | First register operand |
| in_b | input | 64 | Second register operand |
| in_imm | input | 16 | Immediate field |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |
| out_wr_en | output | 1 | Destination register write enable |
| out_ovf | output | 1 | Overflow exception flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- quiet flags while no result is valid;
- an overflow never arriving together with a write;
- no flag from non-trapping opcodes;
- the sign-extension shape of word results;
- the 0/1 range of set-less-than results.

Only the bench's vectors can show the numeric values. These include the exact wrapped sums, which sign bit decides overflow for each size, and sign versus zero extension of the immediate. They also include the unsigned comparison against a sign-extended immediate and the undefined-opcode results.

// File: rtl/adder_pkg.sv
package adder_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADDT_W  = 5'd0,
        OP_ADD_W   = 5'd1,
        OP_SUBT_W  = 5'd2,
        OP_SUB_W   = 5'd3,
        OP_ADDT_D  = 5'd4,
        OP_ADD_D   = 5'd5,
        OP_SUBT_D  = 5'd6,
        OP_SUB_D   = 5'd7,
        OP_ADDIT_W = 5'd8,
        OP_ADDI_W  = 5'd9,
        OP_ADDIT_D = 5'd10,
        OP_ADDI_D  = 5'd11,
        OP_SLT     = 5'd12,
        OP_SLTU    = 5'd13,
        OP_SLTI    = 5'd14,
        OP_SLTIU   = 5'd15,
        OP_AND     = 5'd16,
        OP_OR      = 5'd17,
        OP_XOR     = 5'd18,
        OP_NOR     = 5'd19,
        OP_ANDI    = 5'd20,
        OP_ORI     = 5'd21,
        OP_XORI    = 5'd22,
        OP_LUI     = 5'd23
    } op_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_ARITH,
        K_SLT,
        K_LOGIC,
        K_LUI
    } kind_e;

    typedef enum logic [1:0] {
        L_AND,
        L_OR,
        L_XOR,
        L_NOR
    } lop_e;

    typedef struct packed {
        kind_e kind;
        logic  use_imm;
        logic  imm_sext;
        logic  sub;
        logic  word;
        logic  trap;
        logic  uns;
        lop_e  lop;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OP_W-1:0] op);
        ctl_t c;
        c = '{kind: K_NONE, use_imm: 1'b0, imm_sext: 1'b0, sub: 1'b0,
              word: 1'b0, trap: 1'b0, uns: 1'b0, lop: L_AND};
        unique case (op)
            OP_ADDT_W:  begin c.kind = K_ARITH; c.word = 1'b1; c.trap = 1'b1; end
            OP_ADD_W:   begin c.kind = K_ARITH; c.word = 1'b1; end
            OP_SUBT_W:  begin c.kind = K_ARITH; c.word = 1'b1; c.sub = 1'b1; c.trap = 1'b1; end
            OP_SUB_W:   begin c.kind = K_ARITH; c.word = 1'b1; c.sub = 1'b1; end
            OP_ADDT_D:  begin c.kind = K_ARITH; c.trap = 1'b1; end
            OP_ADD_D:   begin c.kind = K_ARITH; end
            OP_SUBT_D:  begin c.kind = K_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
            OP_SUB_D:   begin c.kind = K_ARITH; c.sub = 1'b1; end
            OP_ADDIT_W: begin c.kind = K_ARITH; c.word = 1'b1; c.trap = 1'b1;
                              c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_ADDI_W:  begin c.kind = K_ARITH; c.word = 1'b1;
                              c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_ADDIT_D: begin c.kind = K_ARITH; c.trap = 1'b1;
                              c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_ADDI_D:  begin c.kind = K_ARITH; c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_SLT:     begin c.kind = K_SLT; end
            OP_SLTU:    begin c.kind = K_SLT; c.uns = 1'b1; end
            OP_SLTI:    begin c.kind = K_SLT; c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_SLTIU:   begin c.kind = K_SLT; c.uns = 1'b1; c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_AND:     begin c.kind = K_LOGIC; c.lop = L_AND; end
            OP_OR:      begin c.kind = K_LOGIC; c.lop = L_OR; end
            OP_XOR:     begin c.kind = K_LOGIC; c.lop = L_XOR; end
            OP_NOR:     begin c.kind = K_LOGIC; c.lop = L_NOR; end
            OP_ANDI:    begin c.kind = K_LOGIC; c.lop = L_AND; c.use_imm = 1'b1; end
            OP_ORI:     begin c.kind = K_LOGIC; c.lop = L_OR;  c.use_imm = 1'b1; end
            OP_XORI:    begin c.kind = K_LOGIC; c.lop = L_XOR; c.use_imm = 1'b1; end
            OP_LUI:     begin c.kind = K_LUI; end
            default:    begin c.kind = K_NONE; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adder_opnd.sv
module adder_opnd #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              imm_sext,
    output logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] upper_imm
);
    localparam int EXT_W = DATA_W - IMM_W;
    localparam int UPR_W = DATA_W - 2 * IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        if (imm_sext) begin
            imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin
            imm_ext = {{EXT_W{1'b0}}, imm};
        end
        opnd_b    = use_imm ? imm_ext : reg_b;
        upper_imm = {{UPR_W{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
    end
endmodule

// File: rtl/adder_arith.sv
module adder_arith #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              word,
    output logic [DATA_W-1:0] sum,
    output logic              ovf,
    output logic              lt_s,
    output logic              lt_u
);
    localparam int EXT_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] raw;
    logic              sa, sb, sr;

    always_comb begin
        b_eff = sub ? ~b : b;
        raw   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
        if (word) begin
            sum = {{EXT_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            sa  = a[HALF_W-1];
            sb  = b[HALF_W-1];
            sr  = raw[HALF_W-1];
        end else begin
            sum = raw;
            sa  = a[DATA_W-1];
            sb  = b[DATA_W-1];
            sr  = raw[DATA_W-1];
        end
        if (sub) begin
            ovf = (sa ^ sb) & (sa ^ sr);
        end else begin
            ovf = ~(sa ^ sb) & (sa ^ sr);
        end
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
    end
endmodule

// File: rtl/adder_logic.sv
module adder_logic #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  adder_pkg::lop_e   lop,
    output logic [DATA_W-1:0] y
);
    import adder_pkg::*;

    always_comb begin
        unique case (lop)
            L_AND:   y = a & b;
            L_OR:    y = a | b;
            L_XOR:   y = a ^ b;
            L_NOR:   y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/adder_exec_unit.sv
module adder_exec_unit
    import adder_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic              out_ovf
);
    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } state_e;

    state_e state_q, state_d;

    ctl_t              ctl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] upper_imm;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic              arith_ovf;
    logic              lt_s, lt_u;
    logic [DATA_W-1:0] res_c;
    logic              wr_c;
    logic              ovf_c;

    assign ctl = decode_op(in_op);

    adder_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .reg_b     (in_b),
        .imm       (in_imm),
        .use_imm   (ctl.use_imm),
        .imm_sext  (ctl.imm_sext),
        .opnd_b    (opnd_b),
        .upper_imm (upper_imm)
    );

    adder_arith #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_arith (
        .a    (in_a),
        .b    (opnd_b),
        .sub  (ctl.sub),
        .word (ctl.word),
        .sum  (arith_y),
        .ovf  (arith_ovf),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    adder_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (in_a),
        .b   (opnd_b),
        .lop (ctl.lop),
        .y   (logic_y)
    );

    always_comb begin
        res_c = '0;
        wr_c  = 1'b1;
        ovf_c = 1'b0;
        unique case (ctl.kind)
            K_ARITH: begin
                res_c = arith_y;
                ovf_c = ctl.trap & arith_ovf;
                wr_c  = ~ovf_c;
            end
            K_SLT:   res_c = {{(DATA_W-1){1'b0}}, (ctl.uns ? lt_u : lt_s)};
            K_LOGIC: res_c = logic_y;
            K_LUI:   res_c = upper_imm;
            default: begin
                res_c = '0;
                wr_c  = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_wr_en  <= 1'b0;
            out_ovf    <= 1'b0;
        end else if (in_valid) begin
            out_result <= res_c;
            out_wr_en  <= wr_c;
            out_ovf    <= ovf_c;
        end else begin
            out_wr_en  <= 1'b0;
            out_ovf    <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_DONE);

endmodule

// File: rtl/adder_exec_chk.sv
module adder_exec_chk
    import adder_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [IMM_W-1:0]  in_imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr_en,
    input logic              out_ovf
);
    logic in_word, in_slt, in_quiet;

    assign in_word  = in_op inside {OP_ADDT_W, OP_ADD_W, OP_SUBT_W, OP_SUB_W,
                                    OP_ADDIT_W, OP_ADDI_W};
    assign in_slt   = in_op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU};
    assign in_quiet = !(in_op inside {OP_ADDT_W, OP_SUBT_W, OP_ADDT_D,
                                      OP_SUBT_D, OP_ADDIT_W, OP_ADDIT_D})
                      && (in_op <= OP_LUI);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wr_en && !out_ovf));
    a_r4_no_write_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> !out_wr_en);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_quiet) |=> (out_wr_en && !out_ovf));
    a_r3_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word) |=>
        (out_result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){out_result[HALF_W-1]}}));
    a_r8_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_slt) |=> (out_result[DATA_W-1:1] == '0));
    a_r11_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OP_LUI) |=> (!out_wr_en && !out_ovf && out_result == '0));

    logic unused_ok;
    assign unused_ok = ^{in_a, in_b, in_imm};
endmodule

bind adder_exec_unit adder_exec_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .in_imm(in_imm), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_ovf(out_ovf)
);

// File: tb/tb_adder_exec_unit.sv
module tb_adder_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [4:0]  in_op;
    logic [63:0] in_a, in_b;
    logic [15:0] in_imm;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wr_en;
    logic        out_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adder_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_imm(in_imm), .out_valid(out_valid),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_ovf(out_ovf)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [15:0] imm;
        logic [63:0] res;
        logic        we;
        logic        ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VT [NV] = '{
        '{5'd0,  64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1, 8'd4},  // R4
        '{5'd0,  64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_0003, 16'h0, 64'h8, 1'b1, 1'b0, 8'd3}, // R3
        '{5'd1,  64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 8'd6},  // R6
        '{5'd2,  64'h0000_0000_8000_0000, 64'h1, 16'h0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, 8'd5},  // R5
        '{5'd3,  64'h0, 64'h1, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 8'd3},                    // R3
        '{5'd4,  64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 8'd4},  // R4
        '{5'd4,  64'h0000_0000_7FFF_FFFF, 64'h1, 16'h0, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 8'd4},  // R4
        '{5'd5,  64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 16'h0, 64'h1, 1'b1, 1'b0, 8'd6},                    // R6
        '{5'd6,  64'h8000_0000_0000_0000, 64'h1, 16'h0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 8'd5},  // R5
        '{5'd6,  64'h5, 64'h7, 16'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 8'd5},                    // R5
        '{5'd7,  64'h8000_0000_0000_0000, 64'h1, 16'h0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 8'd6},  // R6
        '{5'd8,  64'h10, 64'h0, 16'hFFFF, 64'hF, 1'b1, 1'b0, 8'd7},                                  // R7
        '{5'd8,  64'h0000_0000_7FFF_FFFF, 64'h0, 16'h0001, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1, 8'd4}, // R4
        '{5'd9,  64'h0000_0000_7FFF_FFF0, 64'h0, 16'h0020, 64'hFFFF_FFFF_8000_0010, 1'b1, 1'b0, 8'd6}, // R6
        '{5'd10, 64'h8000_0000_0000_0000, 64'h0, 16'h8000, 64'h7FFF_FFFF_FFFF_8000, 1'b0, 1'b1, 8'd4}, // R4
        '{5'd11, 64'h0, 64'h0, 16'h8000, 64'hFFFF_FFFF_FFFF_8000, 1'b1, 1'b0, 8'd7},                 // R7
        '{5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h1, 1'b1, 1'b0, 8'd8},                    // R8
        '{5'd12, 64'h8000_0000_0000_0000, 64'h0, 16'h0, 64'h1, 1'b1, 1'b0, 8'd8},                    // R8
        '{5'd13, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 64'h0, 1'b1, 1'b0, 8'd8},                    // R8
        '{5'd14, 64'h0, 64'h0, 16'hFFFF, 64'h0, 1'b1, 1'b0, 8'd8},                                   // R8
        '{5'd14, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 16'hFFFF, 64'h1, 1'b1, 1'b0, 8'd8},                 // R8
        '{5'd15, 64'h5, 64'h0, 16'hFFFF, 64'h1, 1'b1, 1'b0, 8'd8},                                   // R8
        '{5'd15, 64'h0001_0000, 64'h0, 16'h7FFF, 64'h0, 1'b1, 1'b0, 8'd8},                           // R8
        '{5'd16, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 16'h0, 64'h0F00_0F00_0F00_0F00, 1'b1, 1'b0, 8'd9}, // R9
        '{5'd17, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 16'h0, 64'hFFF0_FFF0_FFF0_FFF0, 1'b1, 1'b0, 8'd9}, // R9
        '{5'd18, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 16'h0, 64'hF0F0_F0F0_F0F0_F0F0, 1'b1, 1'b0, 8'd9}, // R9
        '{5'd19, 64'hF0F0_F0F0_0000_0000, 64'h0F0F_0000_0000_0001, 16'h0, 64'h0000_0F0F_FFFF_FFFE, 1'b1, 1'b0, 8'd9}, // R9
        '{5'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h8001, 64'h8001, 1'b1, 1'b0, 8'd7},              // R7
        '{5'd21, 64'h0, 64'h0, 16'h8000, 64'h8000, 1'b1, 1'b0, 8'd7},                                // R7
        '{5'd22, 64'hFFFF_0000_FFFF_0000, 64'h0, 16'hFFFF, 64'hFFFF_0000_FFFF_FFFF, 1'b1, 1'b0, 8'd7}, // R7
        '{5'd23, 64'h1234, 64'h0, 16'h8000, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 8'd10},             // R10
        '{5'd23, 64'hFFFF, 64'h0, 16'h1234, 64'h0000_0000_1234_0000, 1'b1, 1'b0, 8'd10},             // R10
        '{5'd31, 64'h5, 64'h6, 16'h7, 64'h0, 1'b0, 1'b0, 8'd11},                                     // R11
        '{5'd24, 64'hFFFF, 64'h1, 16'h1, 64'h0, 1'b0, 1'b0, 8'd11}                                   // R11
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] imm);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm;
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_op = 5'd0; in_a = '0; in_b = '0; in_imm = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_in();
        repeat (3) @(negedge clk);
        // R2: outputs quiet during reset, even with a strobe present
        drive(5'd1, 64'h1, 64'h1, 16'h0);
        @(negedge clk);
        check("R2 valid in reset", {63'b0, out_valid}, 64'h0);
        check("R2 wr_en in reset", {63'b0, out_wr_en}, 64'h0);
        check("R2 ovf in reset",   {63'b0, out_ovf},   64'h0);
        idle_in();
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 valid after reset", {63'b0, out_valid}, 64'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].op, VT[i].a, VT[i].b, VT[i].imm);
            @(negedge clk);
            idle_in();
            check($sformatf("R%0d vec %0d result", VT[i].req, i), out_result, VT[i].res);
            check($sformatf("R%0d vec %0d wr_en", VT[i].req, i), {63'b0, out_wr_en}, {63'b0, VT[i].we});
            check($sformatf("R%0d vec %0d ovf", VT[i].req, i), {63'b0, out_ovf}, {63'b0, VT[i].ovf});
            check($sformatf("R1 vec %0d valid", i), {63'b0, out_valid}, 64'h1);
            @(negedge clk);
        end

        // R1: valid low and flags quiet after the strobe drops
        check("R1 valid drops", {63'b0, out_valid}, 64'h0);
        check("R1 wr_en quiet", {63'b0, out_wr_en}, 64'h0);

        // R1: back-to-back operations, one result per cycle
        drive(5'd5, 64'h10, 64'h20, 16'h0);
        @(negedge clk);
        check("R1 b2b first result", out_result, 64'h30);
        check("R1 b2b first valid", {63'b0, out_valid}, 64'h1);
        drive(5'd4, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0);
        @(negedge clk);
        check("R4 b2b second ovf", {63'b0, out_ovf}, 64'h1);
        check("R1 b2b second valid", {63'b0, out_valid}, 64'h1);
        // R12: non-trapping op right after a trap writes with no flag
        drive(5'd17, 64'h0F, 64'hF0, 16'h0);
        @(negedge clk);
        idle_in();
        check("R12 logic after trap wr_en", {63'b0, out_wr_en}, 64'h1);
        check("R12 logic after trap ovf",   {63'b0, out_ovf},   64'h0);
        check("R9 logic after trap result", out_result, 64'hFF);

        // R5: word subtract ignores upper operand bits; negative minus positive wraps
        drive(5'd2, 64'hAAAA_AAAA_8000_0000, 64'h5555_5555_0000_0001, 16'h0);
        @(negedge clk);
        idle_in();
        check("R5 word sub upper ignored ovf", {63'b0, out_ovf}, 64'h1);
        @(negedge clk);

        // R2: reset mid-run clears a pending result
        drive(5'd5, 64'h1, 64'h1, 16'h0);
        @(negedge clk);
        idle_in();
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid-run reset valid", {63'b0, out_valid}, 64'h0);
        check("R2 mid-run reset wr_en", {63'b0, out_wr_en}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule